// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. It runs the sixteen-state test controller from a test clock and a mode-select line, and it places one of four shift paths between the serial data input and the serial data output: a 3-bit instruction register, a single bypass cell, a 32-bit identification register, or a boundary register of parameterized length. The boundary register takes a snapshot of a parallel pin vector. Under the external-test instruction it also drives a parallel update vector, which the I/O ring uses to control the pads. One instruction makes the block assert a flag that turns every functional output driver off.

The port has no dedicated test reset pin. The controller recovers to its reset state when the mode-select line is held high for five clock edges. An active-low power-on reset, `por_n`, sets the same state when the device powers up. Serial inputs are sampled on the rising edge of the test clock. The serial output and its enable change on the falling edge, so a chain of such ports can be shifted back to back.

Top module: `bscan_tap`

## Requirements
- R1: `tms` and `tdi` are sampled on rising `tck` edges. `tdo` and `tdo_en` change only on falling `tck` edges, so `tdo` keeps its value across a rising edge.
- R2: After power-on reset the controller is in Test-Logic-Reset. From any state, five rising edges with `tms` high bring it back to Test-Logic-Reset.
- R3: Capture-IR loads the instruction shift register with binary 001 (low two bits 01, top bit 0). The register shifts least significant bit first.
- R4: A shifted instruction takes effect only on the rising edge that leaves Update-IR. Pausing in Pause-IR leaves the active instruction unchanged.
- R5: The active instruction becomes IDCODE (001) at power-on and on every clock spent in Test-Logic-Reset.
- R6: Instruction codes are: 000 external test, 001 IDCODE, 010 sample with outputs off, 100 sample/preload. The codes 011, 101, 110 and 111 all select the one-bit bypass cell, which captures 0. A scan of N bits through the bypass cell returns 0 followed by the first N-1 input bits.
- R7: Under IDCODE, Capture-DR loads the 32-bit identification constant `ID_VALUE`. The constant leaves `tdo` bit 0 first.
- R8: Under codes 000, 010 and 100, Capture-DR loads the boundary register with `pins_i`. Cells whose bit is set in `CELL_FIXED` have no pin and capture 1. The register shifts bit 0 out first, with `tdi` entering at the top.
- R9: `outs_off` is high exactly while the active instruction is 010.
- R10: `upd_vec` takes the boundary shift register contents at Update-DR only under codes 000 and 100. It holds its value otherwise and is 0 after power-on.
- R11: `tdo_en` is high only while the controller is in Shift-IR or Shift-DR. While `tdo_en` is low, `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in, sampled on rising `tck` |
| pins_i | input | BSR_LEN | Parallel pin values captured by the boundary register |
| tdo | output | 1 | Serial test data out, changes on falling `tck` |
| tdo_en | output | 1 | Drive enable for `tdo` |
| upd_vec | output | BSR_LEN | Latched boundary values for the output pads under external test |
| outs_off | output | 1 | Forces all functional outputs to high impedance |

## Verification
A wrong controller state makes `tdo_en` rise or fall on the wrong falling edge, or makes a capture load the wrong path. Either error corrupts the first serial bit of the next scan, within one clock of the fault. A wrong instruction decode shows up on the next data scan: the returned length or pattern comes from the wrong path (the bypass offset, the ID constant, or the pins with their fixed cells), or `outs_off` or `upd_vec` shows the error one edge after the update state. A broken reset path only appears after the next run of five high `tms` edges, when the scan that follows fails to return the identification constant.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    typedef logic [IR_W-1:0] instr_t;

    localparam instr_t OP_EXTEST     = 3'b000;
    localparam instr_t OP_IDCODE     = 3'b001;
    localparam instr_t OP_HIZ_SAMPLE = 3'b010;
    localparam instr_t OP_SAMPLE     = 3'b100;
    localparam instr_t OP_BYPASS     = 3'b111;
    localparam instr_t IR_CAPTURE    = 3'b001;

    typedef enum logic [1:0] {PATH_BYPASS, PATH_ID, PATH_BOUNDARY} dr_path_e;

    function automatic dr_path_e decode_path(input instr_t op);
        case (op)
            OP_EXTEST, OP_HIZ_SAMPLE, OP_SAMPLE: return PATH_BOUNDARY;
            OP_IDCODE:                           return PATH_ID;
            default:                             return PATH_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e state;
    } fsm_reg_t;

    fsm_reg_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.state)
            TS_RESET:  nxt_d.state = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   nxt_d.state = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: nxt_d.state = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: nxt_d.state = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  nxt_d.state = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: nxt_d.state = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: nxt_d.state = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: nxt_d.state = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: nxt_d.state = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: nxt_d.state = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: nxt_d.state = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  nxt_d.state = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: nxt_d.state = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: nxt_d.state = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: nxt_d.state = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: nxt_d.state = tms ? TS_SEL_DR : TS_IDLE;
            default:   nxt_d.state = TS_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) cur_q <= '{state: TS_RESET};
        else        cur_q <= nxt_d;
    end

    assign state_o = cur_q.state;

    // Run of consecutive high tms samples, saturating at five.
    logic [2:0] ones_q;
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)           ones_q <= 3'd0;
        else if (!tms)        ones_q <= 3'd0;
        else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!por_n)
        (ones_q == 3'd5) |-> (cur_q.state == TS_RESET)); // R2

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tdi,
    input  tap_state_e state_i,
    output instr_t     active_o,
    output logic       sh_lsb_o
);

    typedef struct packed {
        instr_t sh;
        instr_t act;
    } ir_reg_t;

    ir_reg_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (state_i)
            TS_RESET:  nxt_d.act = OP_IDCODE;
            TS_CAP_IR: nxt_d.sh  = IR_CAPTURE;
            TS_SH_IR:  nxt_d.sh  = {tdi, cur_q.sh[IR_W-1:1]};
            TS_UPD_IR: nxt_d.act = cur_q.sh;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) cur_q <= '{sh: '0, act: OP_IDCODE};
        else        cur_q <= nxt_d;
    end

    assign active_o = cur_q.act;
    assign sh_lsb_o = cur_q.sh[0];

    AST_IR_UPDATE_ONLY: assert property (@(posedge tck) disable iff (!por_n)
        ($past(state_i) != TS_UPD_IR && $past(state_i) != TS_RESET) |-> $stable(cur_q.act)); // R4

    AST_IR_DEFAULT_ID: assert property (@(posedge tck) disable iff (!por_n)
        (state_i == TS_RESET) |=> (cur_q.act == OP_IDCODE)); // R5

    AST_IR_CAPTURE_01: assert property (@(posedge tck) disable iff (!por_n)
        ($past(state_i) == TS_CAP_IR) |-> (cur_q.sh[1:0] == 2'b01)); // R3

endmodule

// File: rtl/bscan_dr.sv
module bscan_dr
    import bscan_pkg::*;
#(
    parameter int                 BSR_LEN    = 16,
    parameter logic [ID_W-1:0]    ID_VALUE   = 32'h1A5C_3E01,
    parameter logic [BSR_LEN-1:0] CELL_FIXED = '0
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tdi,
    input  tap_state_e         state_i,
    input  instr_t             instr_i,
    input  logic [BSR_LEN-1:0] pins_i,
    output logic               sh_lsb_o,
    output logic [BSR_LEN-1:0] upd_o
);

    localparam int TOP = BSR_LEN - 1;

    typedef struct packed {
        logic               byp;
        logic [ID_W-1:0]    id;
        logic [BSR_LEN-1:0] bsr;
        logic [BSR_LEN-1:0] upd;
    } dr_reg_t;

    dr_reg_t  cur_q, nxt_d;
    dr_path_e path;
    logic     drives_pads;

    assign path        = decode_path(instr_i);
    assign drives_pads = (instr_i == OP_EXTEST) || (instr_i == OP_SAMPLE);

    always_comb begin
        nxt_d = cur_q;
        case (state_i)
            TS_CAP_DR: begin
                case (path)
                    PATH_ID:       nxt_d.id  = ID_VALUE;
                    PATH_BOUNDARY: nxt_d.bsr = pins_i | CELL_FIXED;
                    default:       nxt_d.byp = 1'b0;
                endcase
            end
            TS_SH_DR: begin
                case (path)
                    PATH_ID:       nxt_d.id  = {tdi, cur_q.id[ID_W-1:1]};
                    PATH_BOUNDARY: nxt_d.bsr = {tdi, cur_q.bsr[TOP:1]};
                    default:       nxt_d.byp = tdi;
                endcase
            end
            TS_UPD_DR: begin
                if (drives_pads) nxt_d.upd = cur_q.bsr;
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        case (path)
            PATH_ID:       sh_lsb_o = cur_q.id[0];
            PATH_BOUNDARY: sh_lsb_o = cur_q.bsr[0];
            default:       sh_lsb_o = cur_q.byp;
        endcase
    end

    assign upd_o = cur_q.upd;

    AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!por_n)
        ($past(state_i) == TS_CAP_DR && $past(instr_i) == OP_IDCODE)
        |-> (cur_q.id == ID_VALUE)); // R7

    AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (!por_n)
        ($past(state_i) == TS_CAP_DR && $past(instr_i) == OP_BYPASS)
        |-> (cur_q.byp == 1'b0)); // R6

    AST_FIXED_CELLS: assert property (@(posedge tck) disable iff (!por_n)
        ($past(state_i) == TS_CAP_DR && $past(instr_i) == OP_SAMPLE)
        |-> ((cur_q.bsr & CELL_FIXED) == CELL_FIXED)); // R8

    AST_UPD_HOLD: assert property (@(posedge tck) disable iff (!por_n)
        ($past(state_i) != TS_UPD_DR) |-> $stable(cur_q.upd)); // R10

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
    import bscan_pkg::*;
#(
    parameter int                 BSR_LEN    = 16,
    parameter logic [31:0]        ID_VALUE   = 32'h1A5C_3E01,
    parameter logic [BSR_LEN-1:0] CELL_FIXED = BSR_LEN'(16'h0090)
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pins_i,
    output logic               tdo,
    output logic               tdo_en,
    output logic [BSR_LEN-1:0] upd_vec,
    output logic               outs_off
);

    tap_state_e state;
    instr_t     active;
    logic       ir_lsb;
    logic       dr_lsb;

    bscan_fsm u_fsm (
        .tck     (tck),
        .por_n   (por_n),
        .tms     (tms),
        .state_o (state)
    );

    bscan_ir u_ir (
        .tck      (tck),
        .por_n    (por_n),
        .tdi      (tdi),
        .state_i  (state),
        .active_o (active),
        .sh_lsb_o (ir_lsb)
    );

    bscan_dr #(
        .BSR_LEN    (BSR_LEN),
        .ID_VALUE   (ID_VALUE),
        .CELL_FIXED (CELL_FIXED)
    ) u_dr (
        .tck      (tck),
        .por_n    (por_n),
        .tdi      (tdi),
        .state_i  (state),
        .instr_i  (active),
        .pins_i   (pins_i),
        .sh_lsb_o (dr_lsb),
        .upd_o    (upd_vec)
    );

    // Falling-edge output stage.
    typedef struct packed {
        logic tdo;
        logic en;
    } out_reg_t;

    out_reg_t out_q, out_d;

    always_comb begin
        out_d = '0;
        case (state)
            TS_SH_IR: out_d = '{tdo: ir_lsb, en: 1'b1};
            TS_SH_DR: out_d = '{tdo: dr_lsb, en: 1'b1};
            default:  ;
        endcase
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tdo      = out_q.tdo;
    assign tdo_en   = out_q.en;
    assign outs_off = (active == OP_HIZ_SAMPLE);

    AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en |-> (state == TS_SH_DR || state == TS_SH_IR)); // R11

    AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!por_n)
        !tdo_en |-> !tdo); // R11

endmodule

// File: tb/bscan_tap_bench.sv
module bscan_tap_bench;

    localparam int              CLK_PERIOD = 10;
    localparam int              B_LEN      = 16;
    localparam logic [31:0]     ID_K       = 32'h1A5C_3E01;
    localparam logic [B_LEN-1:0] FIXED_K   = 16'h0090;

    logic             tck = 1'b0;
    logic             por_n, tms, tdi;
    logic [B_LEN-1:0] pins;
    logic             tdo, tdo_en, outs_off;
    logic [B_LEN-1:0] upd_vec;

    bscan_tap #(.BSR_LEN(B_LEN), .ID_VALUE(ID_K), .CELL_FIXED(FIXED_K)) u_bscan_tap (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pins_i(pins),
        .tdo(tdo), .tdo_en(tdo_en), .upd_vec(upd_vec), .outs_off(outs_off)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    int n_chk = 0, n_fail = 0, r1_bad = 0, en_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One TCK cycle: sample outputs after the falling edge, drive inputs,
    // then confirm tdo did not move on the rising edge (R1).
    task automatic step(input logic t_ms, input logic t_di, output logic t_do, output logic t_en);
        @(negedge tck); #1;
        t_do = tdo; t_en = tdo_en;
        tms = t_ms; tdi = t_di;
        @(posedge tck); #1;
        if (tdo !== t_do || tdo_en !== t_en) r1_bad++;
    endtask

    task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap);
        logic d, e;
        step(1, 0, d, e); if (e) en_bad++;
        step(1, 0, d, e); if (e) en_bad++;
        step(0, 0, d, e); if (e) en_bad++;
        step(0, 0, d, e); if (e) en_bad++;
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], d, e);
            cap[i] = d;
            if (!e) en_bad++;
        end
        step(1, 0, d, e); if (e) en_bad++;
        step(0, 0, d, e); if (e) en_bad++;
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic d, e;
        dout = '0;
        step(1, 0, d, e); if (e) en_bad++;
        step(0, 0, d, e); if (e) en_bad++;
        step(0, 0, d, e); if (e) en_bad++;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], d, e);
            dout[i] = d;
            if (!e) en_bad++;
        end
        step(1, 0, d, e); if (e) en_bad++;
        step(0, 0, d, e); if (e) en_bad++;
    endtask

    task automatic to_reset();
        logic d, e;
        for (int i = 0; i < 5; i++) step(1, 0, d, e);
        step(0, 0, d, e);
    endtask

    // Path length and expected scan-out by instruction code (R6, R7, R8).
    function automatic int path_len(input logic [2:0] c);
        if (c == 3'b001) return 32;
        if (c == 3'b000 || c == 3'b010 || c == 3'b100) return B_LEN;
        return 8;
    endfunction

    function automatic logic [63:0] exp_out(input logic [2:0] c, input logic [63:0] din,
                                            input logic [B_LEN-1:0] p);
        if (c == 3'b001) return {32'h0, ID_K};
        if (c == 3'b000 || c == 3'b010 || c == 3'b100) return {48'h0, p | FIXED_K};
        return (din << 1) & 64'hFF;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog act=%h exp=%h", 64'h0, 64'h1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [2:0]       cap;
        logic [63:0]      dout, din;
        logic [B_LEN-1:0] upd_exp;
        logic             d, e;
        void'($urandom(32'd7321));
        por_n = 0; tms = 1; tdi = 0; pins = '0; upd_exp = '0;
        repeat (3) @(posedge tck);
        #2 por_n = 1;

        @(negedge tck); #1;
        chk(tdo_en == 0 && tdo == 0, "R11 reset", {62'h0, tdo_en, tdo}, 64'h0);
        chk(outs_off == 0, "R9 reset", {63'h0, outs_off}, 64'h0);
        chk(upd_vec == '0, "R10 reset", {48'h0, upd_vec}, 64'h0);

        step(0, 0, d, e);
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] == ID_K, "R5 R7 power-up id", dout, {32'h0, ID_K});

        scan_ir(3'b111, cap);
        chk(cap == 3'b001, "R3 capture-ir", {61'h0, cap}, 64'h1);
        din = 64'hA5;
        scan_dr(8, din, dout);
        chk(dout[7:0] == 8'h4A, "R6 bypass 111", dout, 64'h4A);

        // R4: stop in Pause-IR with the outputs-off code shifted in.
        step(1, 0, d, e); step(1, 0, d, e); step(0, 0, d, e); step(0, 0, d, e);
        step(0, 0, d, e); step(0, 1, d, e); step(1, 0, d, e);
        step(0, 0, d, e);
        chk(outs_off == 0, "R4 pause-ir no effect", {63'h0, outs_off}, 64'h0);
        step(1, 0, d, e); step(1, 0, d, e); step(0, 0, d, e);
        chk(outs_off == 1, "R4 R9 after update-ir", {63'h0, outs_off}, 64'h1);

        pins = 16'h3C05;
        scan_dr(B_LEN, 64'h0, dout);
        chk(dout[15:0] == 16'h3C95, "R8 capture under 010", dout, 64'h3C95);

        scan_ir(3'b100, cap);
        chk(outs_off == 0, "R9 cleared", {63'h0, outs_off}, 64'h0);
        pins = 16'h0000;
        scan_dr(B_LEN, 64'hBEEF, dout);
        chk(dout[15:0] == FIXED_K, "R8 placeholders", dout, {48'h0, FIXED_K});
        chk(upd_vec == 16'hBEEF, "R10 preload", {48'h0, upd_vec}, 64'hBEEF);
        scan_ir(3'b000, cap);
        scan_dr(B_LEN, 64'h1234, dout);
        chk(upd_vec == 16'h1234, "R10 extest", {48'h0, upd_vec}, 64'h1234);
        scan_ir(3'b001, cap);
        scan_dr(32, 64'h0, dout);
        chk(upd_vec == 16'h1234, "R10 hold under id", {48'h0, upd_vec}, 64'h1234);
        upd_exp = 16'h1234;

        for (int k = 0; k < 3; k++) begin
            logic [2:0] rc;
            rc = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
            scan_ir(rc, cap);
            din = 64'h5B + 64'(k);
            scan_dr(8, din, dout);
            chk(dout[7:0] == exp_out(rc, din, pins), "R6 reserved bypass", dout, exp_out(rc, din, pins));
        end

        // R2: wander, then five high tms edges must restore reset and IDCODE.
        scan_ir(3'b111, cap);
        for (int k = 0; k < 7; k++) step(1'($urandom_range(0, 1)), 0, d, e);
        to_reset();
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] == ID_K, "R2 R5 tms reset", dout, {32'h0, ID_K});

        for (int k = 0; k < 30; k++) begin
            logic [2:0] rc;
            int         n;
            rc   = 3'($urandom_range(0, 7));
            pins = B_LEN'($urandom);
            din  = {$urandom, $urandom};
            scan_ir(rc, cap);
            chk(cap == 3'b001, "R3 random", {61'h0, cap}, 64'h1);
            chk(outs_off == (rc == 3'b010), "R9 random", {63'h0, outs_off}, {63'h0, rc == 3'b010});
            n = path_len(rc);
            scan_dr(n, din, dout);
            chk(dout == exp_out(rc, din, pins), "R6 R7 R8 random", dout, exp_out(rc, din, pins));
            if (rc == 3'b000 || rc == 3'b100) upd_exp = din[B_LEN-1:0];
            chk(upd_vec == upd_exp, "R10 random", {48'h0, upd_vec}, {48'h0, upd_exp});
        end

        chk(r1_bad == 0, "R1 tdo stable at rising edge", 64'(r1_bad), 64'h0);
        chk(en_bad == 0, "R11 tdo_en shift only", 64'(en_bad), 64'h0);

        done = 1;
        summary();
        $finish;
    end

endmodule